// File: doc/BRIEF.md
# Wait-State Injecting Word Memory

This block is a synchronous memory of 16-bit words with two byte lanes. It stands in for an instruction or data cache in front of a pipeline that has to cope with stalls. The caller presents a byte address, a write word and a two-bit byte write enable. In the same cycle the block returns the addressed word and a ready flag.

Readiness does not depend on the address. A phase counter starts at zero when reset is released and advances on every clock. It wraps at `PERIOD`, so it always holds the number of cycles since reset modulo `PERIOD`. When the phase is zero the access is refused:
- ready is low;
- a fixed marker word is returned;
- neither byte lane is written.

In every other cycle the stored word is returned, and the enabled lanes take their halves of the write word at the clock edge.

A data-side instance and an instruction-side instance typically use different periods, for example 9 and 13, so that their stalls fall on different cycles.

Top module: `wait_mem`

## Requirements
- R1: The word index is `addr[IDX_W:1]`. Address bit 0 has no effect on which word is read or written.
- R2: `byte_we[0]` writes bits 7:0 of the word from `wdata[7:0]`. `byte_we[1]` writes bits 15:8 from `wdata[15:8]`. A lane whose enable is low keeps its contents.
- R3: Let k be the number of rising clock edges since reset was released. `ready` is low exactly when k mod `PERIOD` is 0 and high otherwise. It is also low while reset is asserted.
- R4: While `ready` is low, `rdata` equals `MARKER`, which is 0xFEED by default.
- R5: While `ready` is low, no byte lane is written, whatever `byte_we` holds.
- R6: While `ready` is high, `rdata` is the addressed word as stored before this cycle's write. A write becomes visible from the next cycle on.
- R7: Asserting reset clears every stored word to zero.
- R8: Instances with different `PERIOD` values each follow their own refusal schedule from the same reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | IDX_W+1 | Byte address |
| wdata | input | 16 | Write word |
| byte_we | input | 2 | Per-lane write enable (bit 0 low byte, bit 1 high byte) |
| rdata | output | 16 | Read word, or the marker while refused |
| ready | output | 1 | High when the access is accepted |

## Verification
A long arithmetic sweep is applied with the data-side period of 9 and a second instance with period 13. The sweep walks odd and even addresses, all four lane-enable combinations and varied write words across many refusal phases. A reference array follows every access, which separates lane-masking faults from indexing faults. Directed cases then do four things:
- aim a full write at a refused cycle and read it back in the next, accepted cycle, which shows write suppression apart from a simple read mux;
- write through an odd address and read through the even one;
- write a single lane;
- reset mid-run and confirm that every word reads zero.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
    localparam logic [WORD_W-1:0] REFUSE_WORD = 16'hFEED;
endpackage

// File: rtl/wsm_sched.sv
module wsm_sched #(
    parameter int PERIOD = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == LAST) st_d.ph = '0;
        else                 st_d.ph = st_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = (st_q.ph != '0);

    // checker: cycles elapsed since the last refusal
    logic [PH_W:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        since_q <= '0;
        else if (!ready_o) since_q <= (PH_W+1)'(1);
        else               since_q <= since_q + 1'b1;
    end

    p_refusal_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (since_q == '0 || since_q == (PH_W+1)'(PERIOD)));
    p_no_late_refusal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (since_q < (PH_W+1)'(PERIOD)));
    p_single_refusal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ready_o);
endmodule

// File: rtl/wsm_lane.sv
module wsm_lane #(
    parameter int IDX_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr,
    input  logic [wsm_pkg::BYTE_W-1:0] wbyte,
    output logic [wsm_pkg::BYTE_W-1:0] rbyte
);
    localparam int WORDS = 1 << IDX_W;

    logic [wsm_pkg::BYTE_W-1:0] store_q [WORDS];

    // storage is registered directly; a next-state copy of the array would be wasteful
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) store_q[i] <= '0;
        end else if (wr) begin
            store_q[idx] <= wbyte;
        end
    end

    assign rbyte = store_q[idx];

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> store_q[$past(idx)] == $past(rbyte));
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> store_q[$past(idx)] == $past(wbyte));
endmodule

// File: rtl/wait_mem.sv
module wait_mem #(
    parameter int IDX_W  = 10,
    parameter int PERIOD = 9,
    parameter logic [wsm_pkg::WORD_W-1:0] MARKER = wsm_pkg::REFUSE_WORD
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W:0]             addr,
    input  logic [wsm_pkg::WORD_W-1:0] wdata,
    input  logic [wsm_pkg::LANES-1:0]  byte_we,
    output logic [wsm_pkg::WORD_W-1:0] rdata,
    output logic                       ready
);
    import wsm_pkg::*;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;

    assign idx = addr[IDX_W:1];

    wsm_sched #(.PERIOD(PERIOD)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (ready)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wsm_lane #(.IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .idx   (idx),
            .wr    (byte_we[g] & ready),
            .wbyte (wdata[g*BYTE_W +: BYTE_W]),
            .rbyte (word[g*BYTE_W +: BYTE_W])
        );
    end

    assign rdata = ready ? word : MARKER;

    p_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> rdata == MARKER);
    p_visible_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && byte_we == 2'b11) ##1 (ready && $past(addr[IDX_W:1]) == addr[IDX_W:1])
        |-> rdata == $past(wdata));
endmodule

// File: tb/sim_wait_mem.sv
`timescale 1ns/1ps
module sim_wait_mem;
    localparam int IW = 4;
    localparam int P0 = 9;
    localparam int P1 = 13;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [IW:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  byte_we = '0;
    logic [15:0] rdata, rdata1;
    logic        ready, ready1;

    int checks = 0;
    int fails  = 0;
    int k = 0;
    bit done = 0;
    logic [15:0] ref_mem [1<<IW];

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) k <= 0; else k <= k + 1;

    wait_mem #(.IDX_W(IW), .PERIOD(P0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .byte_we(byte_we), .rdata(rdata), .ready(ready));
    wait_mem #(.IDX_W(IW), .PERIOD(P1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .byte_we(byte_we), .rdata(rdata1), .ready(ready1));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, k);
        end
    endtask

    task automatic clear_ref();
        for (int i = 0; i < (1<<IW); i++) ref_mem[i] = '0;
    endtask

    task automatic step(input logic [IW:0] a, input logic [15:0] w,
                        input logic [1:0] we, input string tag);
        logic rdy;
        @(negedge clk);
        addr = a; wdata = w; byte_we = we;
        #2;
        rdy = (k % P0) != 0;
        chk("R3", {15'd0, ready}, {15'd0, rdy});
        chk("R8", {15'd0, ready1}, {15'd0, (k % P1) != 0});
        if (rdy) begin
            chk(tag, rdata, ref_mem[a[IW:1]]);
            if (we[0]) ref_mem[a[IW:1]][7:0]  = w[7:0];
            if (we[1]) ref_mem[a[IW:1]][15:8] = w[15:8];
        end else begin
            chk("R4", rdata, 16'hFEED);
        end
    endtask

    task automatic align_refusal();
        while (((k + 1) % P0) != 0) step('0, '0, 2'b00, "R6");
    endtask

    initial begin
        clear_ref();
        repeat (2) @(negedge clk);
        #2;
        chk("R3 reset", {15'd0, ready}, 16'd0);
        chk("R4 reset", rdata, 16'hFEED);
        @(negedge clk);
        rst_n = 1;
        // fresh memory reads zero
        for (int i = 0; i < (1<<IW); i++) step(5'(2*i), '0, 2'b00, "R7 initial");

        // arithmetic sweep across phases, lanes and addresses
        for (int i = 0; i < 2*P0*P1; i++)
            step(5'((i*7) % (2<<IW)), 16'((i*16'h1357) ^ 16'hA5C3), 2'(i % 4), "R1 R2 R6");

        // R5: full write during a refused cycle is dropped
        align_refusal();
        step(5'd2, 16'hFFFF, 2'b11, "R5");
        step(5'd2, 16'h0000, 2'b00, "R5");
        // R1: odd address writes the same word as the even one
        step(5'd5, 16'hBEEF, 2'b11, "R1");
        step(5'd4, 16'h0000, 2'b00, "R1");
        // R2: single-lane write
        step(5'd6, 16'h1111, 2'b11, "R2");
        step(5'd6, 16'hAB22, 2'b10, "R2");
        step(5'd6, 16'h0000, 2'b00, "R2");
        // R6: same-cycle read returns the old word
        step(5'd8, 16'h7777, 2'b11, "R6");
        step(5'd8, 16'h8888, 2'b11, "R6");
        step(5'd8, 16'h0000, 2'b00, "R6");

        // R7: reset mid-run clears everything
        @(negedge clk);
        rst_n = 0;
        #2;
        chk("R7 ready", {15'd0, ready}, 16'd0);
        @(negedge clk);
        rst_n = 1;
        clear_ref();
        for (int i = 0; i < (1<<IW); i++) step(5'(2*i + 1), '0, 2'b00, "R7");
        for (int i = 0; i < (1<<IW); i++) step(5'(2*i), '0, 2'b00, "R7");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule